// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

The block moves data between system memory and a device-side data port. Memory is reached through a simple request/acknowledge port, and the engine is steered by a table of descriptors that also sits in memory. Software writes the table's base address into a register. It then writes a control word that carries the direction, a descriptor-mode enable and a start bit. The engine reads the base address once, when the run begins. It fetches two-word descriptors one after another. Each descriptor holds a buffer address whose bit 0 marks the final entry, followed by a byte length. For each segment the engine streams 32-bit beats until the length is used up, and the final beat carries partial byte enables.

A run ends in one of three ways. It finishes normally after the flagged descriptor, it stops on an error from a bad length or a missing mode bit, or software stops it. A stop request takes effect as soon as no memory handshake is half-done. Status exposes a live activity bit and a set of sticky event flags that software clears by writing 1. A device interrupt input is latched into status, and a held engine-reset bit in the control word keeps the block quiet.

Top module: `sgdma_ctrl`

## Requirements
- R1: After reset the control, status and base registers (register addresses 0, 1 and 2) read 0 and no memory request is raised.
- R2: A control write with bit 0 (start) = 1, bit 1 (stop) = 0, bit 3 (descriptor mode) = 1 and bit 7 (engine reset) = 0 while idle starts a run: status bit 0 (active) and control bit 0 read 1 from the next cycle on.
- R3: The table base is taken once at start; writing the base register during a run does not change which descriptors are used.
- R4: Descriptor n sits at base+8n: word 0 is the buffer address with bit 0 as the last-entry flag (masked off from the address), word 1 the byte length; descriptors are processed in table order and memory addresses stay even.
- R5: With control bit 2 = 0 (memory to device), memory words are read at increasing addresses and presented on the device output with byte enables; the final beat of a segment enables only the low (length mod 4) byte lanes when that is not 0.
- R6: With control bit 2 = 1 (device to memory), device words are written to memory with byte enables; bytes beyond the segment length are left unchanged.
- R7: After the last byte of the flagged descriptor, active drops, status bit 1 (normal end) and bit 6 (descriptor end) are set, and control bit 0 reads 0.
- R8: A length of 0 or above 2^29 sets status bit 2 (error), ends the run and moves no data for that descriptor.
- R9: A segment of exactly 2^29 bytes is accepted, and addresses continue linearly across 64 KB boundaries.
- R10: A control write with bit 1 set while control bit 0 is 1 clears control bit 0 in the next cycle, ends the run once no memory handshake is pending, and sets status bit 5 (terminated) without normal end.
- R11: The device interrupt input sets status bit 4 and holds it; writing 1 to status bits 1, 2, 4, 5 or 6 clears them, and writing 0 leaves them.
- R12: A start with control bit 3 = 0 sets the error bit and moves no data.
- R13: While control bit 7 is 1, start writes are ignored and the sticky status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address (0 control, 1 status, 2 base) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory write byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| dev_out_valid | output | 1 | Beat toward the device is valid |
| dev_out_data | output | 32 | Beat data toward the device |
| dev_out_be | output | 4 | Byte enables of the outgoing beat |
| dev_out_ready | input | 1 | Device accepts the outgoing beat |
| dev_in_valid | input | 1 | Device offers a beat |
| dev_in_data | input | 32 | Beat data from the device |
| dev_in_ready | output | 1 | Engine accepts the incoming beat |
| dev_irq | input | 1 | Device interrupt request |

## Verification
Memory-to-device runs use tables with a whole-word segment, a segment with a two-byte tail and a flagged single-word entry. Variable memory latency and a throttled device show whether beats keep their order and lanes under backpressure. Device-to-memory runs check against memory bytes seeded with a marker, which separates correct tail masking from writes past the length. A 2^29-byte segment placed just below a 64 KB line is stopped partway through. This one run shows whether the length is accepted, whether addresses continue across the boundary, and whether termination is reported instead of a normal end. Zero and oversized lengths, a start without descriptor mode, a base rewrite during a run and the held engine reset each have a known effect on status and must move no stray data.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int WORD_W  = 32;
  localparam int BE_W    = WORD_W / 8;
  localparam int RADDR_W = 2;

  localparam logic [RADDR_W-1:0] RA_CTRL = 2'd0;
  localparam logic [RADDR_W-1:0] RA_STAT = 2'd1;
  localparam logic [RADDR_W-1:0] RA_BASE = 2'd2;

  localparam int CB_GO   = 0;
  localparam int CB_HALT = 1;
  localparam int CB_DIR  = 2;
  localparam int CB_DESC = 3;
  localparam int CB_RST  = 7;
  localparam int CB_W32  = 11;
  localparam int CB_ISM  = 16;

  localparam int SB_ACT    = 0;
  localparam int SB_NEND   = 1;
  localparam int SB_ERR    = 2;
  localparam int SB_DEVINT = 4;
  localparam int SB_DEVTRM = 5;
  localparam int SB_DNEND  = 6;

  localparam logic [WORD_W-1:0] STICKY_MASK =
    (32'd1 << SB_NEND) | (32'd1 << SB_ERR) | (32'd1 << SB_DEVINT) |
    (32'd1 << SB_DEVTRM) | (32'd1 << SB_DNEND);
  localparam logic [WORD_W-1:0] CTRL_KEEP_MASK =
    (32'd1 << CB_DIR) | (32'd1 << CB_DESC) | (32'd1 << CB_RST) |
    (32'd1 << CB_W32) | (32'd1 << CB_ISM);

  typedef enum logic [2:0] {
    E_IDLE, E_FETCH_A, E_FETCH_L, E_MEM_RD, E_DEV_OUT, E_DEV_IN, E_MEM_WR
  } eng_state_t;

  // byte lanes of the next beat given the bytes still owed in the segment
  function automatic logic [BE_W-1:0] beat_be(input logic [31:0] left);
    case (left)
      32'd1:   return 4'b0001;
      32'd2:   return 4'b0011;
      32'd3:   return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // bytes consumed by the next beat
  function automatic logic [2:0] beat_bytes(input logic [31:0] left);
    return (left >= 32'd4) ? 3'd4 : left[2:0];
  endfunction

  function automatic logic len_ok(input logic [31:0] len, input logic [31:0] max_len);
    return (len != 32'd0) && (len <= max_len);
  endfunction
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [RADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               dev_irq,
  input  logic               eng_busy,
  input  logic               ev_desc_done,
  input  logic               ev_normal_end,
  input  logic               ev_error,
  input  logic               ev_term,
  output logic               go,
  output logic               go_dir,
  output logic [WORD_W-1:0]  go_base,
  output logic               abort_req,
  output logic               start_bit
);
  logic [WORD_W-1:0] ctrl_q, ctrl_nxt, stat_q, stat_nxt, base_q;
  logic ctrl_wr, stat_wr, base_wr, start_try, mode_err;

  assign ctrl_wr = wr_en && (wr_addr == RA_CTRL);
  assign stat_wr = wr_en && (wr_addr == RA_STAT);
  assign base_wr = wr_en && (wr_addr == RA_BASE);

  assign start_try = ctrl_wr && wr_data[CB_GO] && !wr_data[CB_HALT] &&
                     !wr_data[CB_RST] && !ctrl_q[CB_GO] && !eng_busy;
  assign go        = start_try && wr_data[CB_DESC];
  assign mode_err  = start_try && !wr_data[CB_DESC];
  assign go_dir    = wr_data[CB_DIR];
  assign go_base   = base_q;
  assign abort_req = ctrl_wr && ctrl_q[CB_GO] && (wr_data[CB_HALT] || wr_data[CB_RST]);
  assign start_bit = ctrl_q[CB_GO];

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (ctrl_wr) ctrl_nxt = wr_data & CTRL_KEEP_MASK;
    ctrl_nxt[CB_GO] = go | (ctrl_q[CB_GO] & ~abort_req & ~ev_normal_end &
                            ~ev_error & ~ev_term);
  end

  always_comb begin
    stat_nxt = stat_q;
    if (stat_wr) stat_nxt = stat_q & ~(wr_data & STICKY_MASK);
    if (ev_normal_end)        stat_nxt[SB_NEND]   = 1'b1;
    if (ev_error || mode_err) stat_nxt[SB_ERR]    = 1'b1;
    if (dev_irq)              stat_nxt[SB_DEVINT] = 1'b1;
    if (ev_term)              stat_nxt[SB_DEVTRM] = 1'b1;
    if (ev_desc_done)         stat_nxt[SB_DNEND]  = 1'b1;
    stat_nxt = stat_nxt & STICKY_MASK;
    if (ctrl_nxt[CB_RST]) stat_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      base_q <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      stat_q <= stat_nxt;
      if (base_wr) base_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      RA_CTRL: rd_data = ctrl_q;
      RA_STAT: rd_data = stat_q | (WORD_W'(eng_busy) << SB_ACT);
      RA_BASE: rd_data = base_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int MAX_SEG_BYTES = 2**29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_dir,
  input  logic [WORD_W-1:0] go_base,
  input  logic              abort_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dev_out_valid,
  output logic [WORD_W-1:0] dev_out_data,
  output logic [BE_W-1:0]   dev_out_be,
  input  logic              dev_out_ready,
  input  logic              dev_in_valid,
  input  logic [WORD_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              busy,
  output logic              ev_desc_done,
  output logic              ev_normal_end,
  output logic              ev_error,
  output logic              ev_term
);
  localparam int LEN_W = $clog2(MAX_SEG_BYTES) + 1;
  localparam logic [WORD_W-1:0] MAX_LEN = WORD_W'(MAX_SEG_BYTES);

  eng_state_t        state, after_beat;
  logic [WORD_W-1:0] ptr, seg_addr, buf_q;
  logic [LEN_W-1:0]  left;
  logic              is_last, dir_q, halt_pend;
  logic              fetching, halt_now, beat_fire, seg_end, len_bad;

  assign fetching      = (state == E_FETCH_A) || (state == E_FETCH_L);
  assign busy          = (state != E_IDLE);
  assign mem_req       = fetching || (state == E_MEM_RD) || (state == E_MEM_WR);
  assign mem_we        = (state == E_MEM_WR);
  assign mem_addr      = fetching ? ptr : seg_addr;
  assign mem_be        = fetching ? {BE_W{1'b1}} : beat_be(32'(left));
  assign mem_wdata     = buf_q;
  assign dev_out_valid = (state == E_DEV_OUT);
  assign dev_out_data  = buf_q;
  assign dev_out_be    = beat_be(32'(left));
  assign dev_in_ready  = (state == E_DEV_IN);

  // a stop lands only between memory handshakes
  assign halt_now  = busy && (halt_pend || abort_req) && (!mem_req || mem_ack);
  assign beat_fire = !halt_now && (((state == E_MEM_WR) && mem_ack) ||
                                   ((state == E_DEV_OUT) && dev_out_ready));
  assign seg_end   = beat_fire && (left <= LEN_W'(4));
  assign len_bad   = !halt_now && (state == E_FETCH_L) && mem_ack &&
                     !len_ok(mem_rdata, MAX_LEN);

  assign ev_desc_done  = seg_end;
  assign ev_normal_end = seg_end && is_last;
  assign ev_error      = len_bad;
  assign ev_term       = halt_now;

  always_comb begin
    if (left <= LEN_W'(4)) after_beat = is_last ? E_IDLE : E_FETCH_A;
    else                   after_beat = dir_q ? E_DEV_IN : E_MEM_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= E_IDLE;
      ptr       <= '0;
      seg_addr  <= '0;
      buf_q     <= '0;
      left      <= '0;
      is_last   <= 1'b0;
      dir_q     <= 1'b0;
      halt_pend <= 1'b0;
    end else begin
      if (halt_now || !busy) halt_pend <= 1'b0;
      else if (abort_req)    halt_pend <= 1'b1;

      if (halt_now) begin
        state <= E_IDLE;
      end else begin
        case (state)
          E_IDLE: if (go) begin
            ptr   <= go_base & ~WORD_W'(3);
            dir_q <= go_dir;
            state <= E_FETCH_A;
          end
          E_FETCH_A: if (mem_ack) begin
            seg_addr <= {mem_rdata[WORD_W-1:1], 1'b0};
            is_last  <= mem_rdata[0];
            ptr      <= ptr + WORD_W'(4);
            state    <= E_FETCH_L;
          end
          E_FETCH_L: if (mem_ack) begin
            ptr  <= ptr + WORD_W'(4);
            left <= mem_rdata[LEN_W-1:0];
            if (len_bad) state <= E_IDLE;
            else         state <= dir_q ? E_DEV_IN : E_MEM_RD;
          end
          E_MEM_RD: if (mem_ack) begin
            buf_q <= mem_rdata;
            state <= E_DEV_OUT;
          end
          E_DEV_IN: if (dev_in_valid) begin
            buf_q <= dev_in_data;
            state <= E_MEM_WR;
          end
          E_DEV_OUT, E_MEM_WR: if (beat_fire) begin
            seg_addr <= seg_addr + WORD_W'(4);
            left     <= left - LEN_W'(beat_bytes(32'(left)));
            state    <= after_beat;
          end
          default: state <= E_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int MAX_SEG_BYTES = 2**29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [RADDR_W-1:0] reg_wr_addr,
  input  logic [WORD_W-1:0]  reg_wr_data,
  input  logic [RADDR_W-1:0] reg_rd_addr,
  output logic [WORD_W-1:0]  reg_rd_data,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [BE_W-1:0]    mem_be,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               dev_out_valid,
  output logic [WORD_W-1:0]  dev_out_data,
  output logic [BE_W-1:0]    dev_out_be,
  input  logic               dev_out_ready,
  input  logic               dev_in_valid,
  input  logic [WORD_W-1:0]  dev_in_data,
  output logic               dev_in_ready,
  input  logic               dev_irq
);
  logic              go, go_dir, abort_req, start_bit;
  logic [WORD_W-1:0] go_base;
  logic              eng_busy, ev_desc_done, ev_normal_end, ev_error, ev_term;

  sgdma_regs u_regs (
    .clk, .rst_n,
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .dev_irq, .eng_busy, .ev_desc_done, .ev_normal_end, .ev_error, .ev_term,
    .go, .go_dir, .go_base, .abort_req, .start_bit
  );

  sgdma_engine #(.MAX_SEG_BYTES(MAX_SEG_BYTES)) u_engine (
    .clk, .rst_n, .go, .go_dir, .go_base, .abort_req,
    .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ack, .mem_rdata,
    .dev_out_valid, .dev_out_data, .dev_out_be, .dev_out_ready,
    .dev_in_valid, .dev_in_data, .dev_in_ready,
    .busy(eng_busy), .ev_desc_done, .ev_normal_end, .ev_error, .ev_term
  );
endmodule

// File: rtl/sgdma_ctrl_chk.sv
module sgdma_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        dev_out_valid,
  input logic [3:0]  dev_out_be,
  input logic        eng_busy,
  input logic        ev_normal_end,
  input logic        ev_error,
  input logic        ev_term,
  input logic        abort_req,
  input logic        start_bit
);
  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_addr_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  p_beat_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid |-> dev_out_be[0]);

  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_normal_end |=> !eng_busy && !start_bit);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_error |=> !eng_busy);

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_normal_end, ev_error, ev_term}));

  p_stop_clears_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !start_bit);
endmodule

bind sgdma_ctrl sgdma_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_addr(mem_addr), .dev_out_valid(dev_out_valid),
  .dev_out_be(dev_out_be), .eng_busy(eng_busy), .ev_normal_end(ev_normal_end),
  .ev_error(ev_error), .ev_term(ev_term), .abort_req(abort_req),
  .start_bit(start_bit)
);

// File: tb/sgdma_ctrl_tb_top.sv
`timescale 1ns/1ps
module sgdma_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dev_out_valid;
  logic [31:0] dev_out_data;
  logic [3:0]  dev_out_be;
  logic        dev_out_ready = 1'b0;
  logic        dev_in_valid = 1'b0;
  logic [31:0] dev_in_data = '0;
  logic        dev_in_ready;
  logic        dev_irq = 1'b0;

  always #2 clk = ~clk;

  sgdma_ctrl dut_i (.*);

  typedef struct { logic [31:0] d; logic [3:0] be; } beat_t;
  beat_t       exp_q[$];
  logic [31:0] src_q[$];
  logic [31:0] mem [0:2047];
  int n_chk = 0, n_bad = 0, lat = 1, wcnt = 0, cyc = 0;
  int sink_beats = 0, sink_limit = 1000000;
  bit finished = 0;

  localparam logic [31:0] C_GO = 32'h1, C_HALT = 32'h2, C_DIR = 32'h4,
                          C_DESC = 32'h8, C_RST = 32'h80, C_MODE = 32'h10808;

  function automatic int idx(input logic [31:0] a);
    return int'(a[12:2]);
  endfunction

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // memory model: acknowledge after lat idle cycles, one request at a time
  always @(negedge clk) begin
    cyc++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req && rst_n) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = mem[idx(mem_addr)];
      end else wcnt++;
    end
    dev_out_ready = (sink_beats < sink_limit) && (cyc % 3 != 1);
    dev_in_valid  = (src_q.size() > 0) && (cyc % 4 != 2);
    dev_in_data   = (src_q.size() > 0) ? src_q[0] : 32'h0;
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[idx(mem_addr)][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (rst_n && dev_in_valid && dev_in_ready) void'(src_q.pop_front());
  end

  // scoreboard monitor on the device output
  always @(posedge clk) begin
    beat_t e;
    if (rst_n && dev_out_valid && dev_out_ready) begin
      sink_beats++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected beat act=%h exp=none", dev_out_data);
      end else begin
        e = exp_q.pop_front();
        if (dev_out_be !== e.be ||
            (dev_out_data & lanes(e.be)) !== (e.d & lanes(e.be))) begin
          n_bad++;
          $display("FAIL R5 beat act=%h/%b exp=%h/%b", dev_out_data, dev_out_be, e.d, e.be);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #0.5;
    d = reg_rd_data;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      reg_read(2'd1, s);
      if (!s[0]) return;
    end
    chk({req, " run did not end"}, 1, 0);
  endtask

  task automatic put_desc(input logic [31:0] tbl, input int n, input logic [31:0] a,
                          input logic [31:0] len, input bit last);
    mem[idx(tbl + 8*n)]     = a | 32'(last);
    mem[idx(tbl + 8*n + 4)] = len;
  endtask

  task automatic expect_seg(input logic [31:0] a, input int len);
    beat_t e;
    for (int off = 0; off < len; off += 4) begin
      e.d  = mem[idx(a + off)];
      e.be = (len - off >= 4) ? 4'hF : 4'((1 << (len - off)) - 1);
      exp_q.push_back(e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int b0;
    beat_t e;
    for (int i = 0; i < 2048; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0003;
    for (int i = 12'h600; i < 12'h610; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    reg_read(2'd0, r); chk("R1 ctrl", r, 0);
    reg_read(2'd1, r); chk("R1 status", r, 0);
    reg_read(2'd2, r); chk("R1 base", r, 0);
    chk("R1 mem_req", 32'(mem_req), 0);

    // R2 R4 R5 R7 memory to device, three descriptors
    put_desc(32'h1000, 0, 32'h100, 8, 0);
    put_desc(32'h1000, 1, 32'h200, 6, 0);
    put_desc(32'h1000, 2, 32'h300, 4, 1);
    expect_seg(32'h100, 8); expect_seg(32'h200, 6); expect_seg(32'h300, 4);
    reg_write(2'd2, 32'h1000);
    reg_write(2'd0, C_MODE | C_GO);
    reg_read(2'd1, r); chk("R2 active after start", r & 1, 1);
    reg_read(2'd0, r); chk("R2 start bit reads 1", r & 1, 1);
    wait_idle("R7");
    chk("R4 all descriptors consumed", exp_q.size(), 0);
    reg_read(2'd1, r); chk("R7 normal and descriptor end", r, 32'h42);
    reg_read(2'd0, r); chk("R7 start bit cleared", r & 1, 0);
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, r); chk("R11 write 0 keeps flags", r, 32'h42);
    reg_write(2'd1, 32'h7E);
    reg_read(2'd1, r); chk("R11 write 1 clears", r, 0);

    // R3 base read once; rewrite base during run
    lat = 2;
    expect_seg(32'h100, 8); expect_seg(32'h200, 6); expect_seg(32'h300, 4);
    reg_write(2'd0, C_MODE | C_GO);
    reg_write(2'd2, 32'h1800);
    wait_idle("R3");
    chk("R3 original table used", exp_q.size(), 0);
    reg_read(2'd1, r); chk("R3 status", r, 32'h42);
    reg_write(2'd1, 32'h7E);

    // R6 device to memory with tail
    lat = 0;
    put_desc(32'h1100, 0, 32'h400, 12, 0);
    put_desc(32'h1100, 1, 32'h500, 5, 1);
    for (int i = 12'h100; i < 12'h142; i++) mem[i] = 32'hDEAD_BEEF;
    src_q = '{32'hA0A1A2A3, 32'hB0B1B2B3, 32'hC0C1C2C3, 32'hD0D1D2D3, 32'hE0E1E2E3};
    reg_write(2'd2, 32'h1100);
    reg_write(2'd0, C_MODE | C_DIR | C_GO);
    wait_idle("R6");
    chk("R6 word0", mem[idx(32'h400)], 32'hA0A1A2A3);
    chk("R6 word2", mem[idx(32'h408)], 32'hC0C1C2C3);
    chk("R6 past segment untouched", mem[idx(32'h40C)], 32'hDEAD_BEEF);
    chk("R6 full beat of second segment", mem[idx(32'h500)], 32'hD0D1D2D3);
    chk("R6 tail lane only", mem[idx(32'h504)], 32'hDEAD_BEE3);
    chk("R6 source drained", src_q.size(), 0);
    reg_read(2'd1, r); chk("R7 status after write run", r, 32'h42);
    reg_write(2'd1, 32'h7E);

    // R8 zero length
    lat = 1;
    put_desc(32'h1200, 0, 32'h100, 0, 1);
    b0 = sink_beats;
    reg_write(2'd2, 32'h1200);
    reg_write(2'd0, C_MODE | C_GO);
    wait_idle("R8");
    reg_read(2'd1, r); chk("R8 zero length error", r, 32'h04);
    reg_read(2'd0, r); chk("R8 start cleared", r & 1, 0);
    chk("R8 no beats", sink_beats - b0, 0);
    reg_write(2'd1, 32'h7E);

    // R8 oversized length
    put_desc(32'h1200, 0, 32'h100, 32'h2000_0001, 1);
    reg_write(2'd0, C_MODE | C_GO);
    wait_idle("R8");
    reg_read(2'd1, r); chk("R8 oversize error", r, 32'h04);
    chk("R8 no beats oversize", sink_beats - b0, 0);
    reg_write(2'd1, 32'h7E);

    // R9 R10 maximal segment across a 64 KB line, then stop
    put_desc(32'h1300, 0, 32'hFFF8, 32'h2000_0000, 1);
    for (int k = 0; k < 4; k++) begin
      e.d = mem[idx(32'hFFF8 + 4*k)]; e.be = 4'hF; exp_q.push_back(e);
    end
    b0 = sink_beats;
    sink_limit = b0 + 4;
    reg_write(2'd2, 32'h1300);
    reg_write(2'd0, C_MODE | C_GO);
    for (int i = 0; i < 500 && sink_beats < sink_limit; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    reg_read(2'd1, r); chk("R9 max segment still active", r, 32'h01);
    chk("R9 beats across boundary", exp_q.size(), 0);
    reg_write(2'd0, C_MODE | C_HALT);
    reg_read(2'd0, r); chk("R10 start reads 0 after stop", r & 1, 0);
    wait_idle("R10");
    reg_read(2'd1, r); chk("R10 terminated flag only", r, 32'h20);
    chk("R10 no beats past limit", sink_beats - b0, 4);
    sink_limit = 1000000;
    reg_write(2'd1, 32'h7E);

    // R12 start without descriptor mode
    reg_write(2'd2, 32'h1000);
    b0 = sink_beats;
    reg_write(2'd0, C_GO);
    reg_read(2'd1, r); chk("R12 error, not active", r, 32'h04);
    repeat (10) @(negedge clk);
    chk("R12 no beats", sink_beats - b0, 0);
    reg_write(2'd1, 32'h7E);

    // R11 device interrupt
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    reg_read(2'd1, r); chk("R11 devint set", r, 32'h10);
    repeat (3) @(negedge clk);
    reg_read(2'd1, r); chk("R11 devint held", r, 32'h10);

    // R13 engine reset bit
    reg_write(2'd0, C_RST);
    reg_read(2'd1, r); chk("R13 status cleared", r, 0);
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    reg_read(2'd1, r); chk("R13 irq ignored in reset", r, 0);
    reg_write(2'd0, C_RST | C_DESC | C_GO);
    reg_read(2'd1, r); chk("R13 start ignored", r, 0);
    repeat (10) @(negedge clk);
    chk("R13 no beats", sink_beats - b0, 0);
    reg_write(2'd0, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule